// File: doc/BRIEF.md
# Serial EEPROM Target with Page Write Buffer

This block is a synthesizable two-wire (I2C) target that behaves like a small serial EEPROM. It samples SCL and SDA on a fast system clock, finds START and STOP conditions, and answers a fixed 7-bit device address. A write transfer carries two word-address bytes, then data bytes. The data bytes collect in a one-page buffer, and a STOP copies the buffered bytes into the storage array during a timed internal write cycle. For the whole of that cycle the target keeps off the bus. Reads return bytes from an internal address counter, which steps through the whole active address space.

The word address is split into an in-page offset of `OFFS_BITS` bits (64-byte pages by default) and a page number of `PAGE_BITS` bits. Any word-address bits above those are ignored. In the full-size setting (8 page bits, 6 offset bits) the top 2 bits of the 16 are ignored. The default has 4 page bits, which keeps the array at 1 KB. SDA is driven open-drain: `sda_oe` high means the target pulls the line low.

The bus controller is a single state machine with these states:
- `S_IDLE`: waits for a START.
- `S_DEV`: shifts in the device byte. On the 8th SCL fall it goes to `S_DEV_ACK` on an address match when not busy. Otherwise it returns to `S_IDLE`.
- `S_DEV_ACK`: drives the acknowledge. On the SCL fall it goes to `S_RDAT` for a read or to `S_AHI` for a write.
- `S_AHI` and `S_AHI_ACK`: receive and acknowledge the high address byte. Then the controller moves to `S_ALO`.
- `S_ALO` and `S_ALO_ACK`: receive and acknowledge the low address byte. Then the controller moves to `S_WDAT`.
- `S_WDAT` and `S_WDAT_ACK`: receive and acknowledge data bytes. After each acknowledge the controller loops back to `S_WDAT`.
- `S_RDAT`: sends 8 bits, then goes to `S_RACK`.
- `S_RACK`: samples the controller's acknowledge. On ACK it returns to `S_RDAT`; on NACK it goes to `S_IDLE`.

From any state, a STOP leads to `S_IDLE`. A START leads to `S_DEV`, or to `S_IDLE` while a write cycle runs.

Top module: `eeprom_i2c_target`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe` is 0 and `busy` is 0.
- R2: The target pulls SDA low during the 9th clock of a device byte only when the byte's upper 7 bits equal `DEV_ADDR`. On a mismatch it drives nothing and ignores all bytes until the next START.
- R3: After a device byte with bit 0 = 0, the target acknowledges two more bytes, high byte first. They form the word address: bits [OFFS_BITS-1:0] are the offset and the next PAGE_BITS bits are the page. All bits above those are ignored.
- R4: Every data byte after the address bytes is acknowledged and goes into the page buffer at the current offset. The offset then increments modulo the page size while the page stays fixed, so byte 65 overwrites byte 1's slot.
- R5: A STOP after at least one data byte raises `busy` on the next clock. `busy` stays high for exactly `WR_CYCLES` clocks. During that time the buffered bytes are written into the array at the latched page, and only the offsets written in that transfer change.
- R6: While `busy` is high, the target never pulls SDA and does not acknowledge its own device address.
- R7: A STOP that follows the two address bytes with no data byte loads the address counter and starts no write cycle.
- R8: A device byte with bit 0 = 1 returns bytes MSB first, starting at the address counter. The counter increments after each byte across the whole active space and wraps from the top address to 0. A controller ACK continues the read; a NACK ends it and SDA is released.
- R9: The address counter keeps its value across a STOP, so a read with no word address continues from where the last transfer left off.
- R10: `sda_oe` changes only while SCL is low, so the target never makes a START or STOP of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy | output | 1 | High during the internal write cycle |

## Verification
The bench writes whole pages at the lowest and highest page and reads them back with random reads. A design that committed to the wrong page, or failed to increment the offset, would return mismatching bytes. A 70-byte write that starts near the end of a page checks the in-page wrap: a design that carried into the next page would damage the neighbouring page's preset bytes, and one that dropped late bytes would keep stale values. A short write into a filled page shows whether unwritten slots are left untouched; a design that committed the whole buffer would clobber them. Further tests cover aliased high address bits, a read that wraps past the top address, address-only transfers that must not start a write cycle, and address attempts during the write cycle, which must get no acknowledge.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_AHI,
        S_AHI_ACK,
        S_ALO,
        S_ALO_ACK,
        S_WDAT,
        S_WDAT_ACK,
        S_RDAT,
        S_RACK
    } bus_state_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import eeprom_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
    parameter int CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(CYCLES - 1)) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
    parameter int PAGE_BITS = 4,
    parameter int OFFS_BITS = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           buf_clr,
    input  logic                           buf_we,
    input  logic [OFFS_BITS-1:0]           buf_off,
    input  logic [7:0]                     buf_wdata,
    input  logic                           commit_go,
    input  logic [PAGE_BITS-1:0]           commit_page,
    input  logic [PAGE_BITS+OFFS_BITS-1:0] rd_addr,
    output logic [7:0]                     rd_data,
    output logic                           commit_active
);

    localparam int AW      = PAGE_BITS + OFFS_BITS;
    localparam int PAGE_SZ = 1 << OFFS_BITS;
    localparam int DEPTH   = 1 << AW;

    logic [7:0]           mem  [DEPTH];
    logic [7:0]           pbuf [PAGE_SZ];
    logic [PAGE_SZ-1:0]   valid;
    logic [OFFS_BITS-1:0] idx;
    logic [PAGE_BITS-1:0] page_q;

    // page buffer contents
    always_ff @(posedge clk) begin
        if (buf_we) begin
            pbuf[buf_off] <= buf_wdata;
        end
    end

    // per-slot written marks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (buf_clr) begin
            valid <= '0;
        end else if (buf_we) begin
            valid[buf_off] <= 1'b1;
        end
    end

    // commit walker: one slot per clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_active <= 1'b0;
            idx           <= '0;
            page_q        <= '0;
        end else if (commit_go) begin
            commit_active <= 1'b1;
            idx           <= '0;
            page_q        <= commit_page;
        end else if (commit_active) begin
            idx <= idx + OFFS_BITS'(1);
            if (idx == '1) begin
                commit_active <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (commit_active && valid[idx]) begin
            mem[{page_q, idx}] <= pbuf[idx];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         PAGE_BITS   = 4,
    parameter int         OFFS_BITS   = 6,
    parameter int         WR_CYCLES   = 600,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic busy
);

    localparam int AW      = PAGE_BITS + OFFS_BITS;
    localparam int HI_BITS = AW - 8;

    bus_evt_t             bus_evt;
    bus_state_t           state;
    bus_state_t           state_nx;
    logic [3:0]           bitcnt;
    logic [7:0]           rx_sh;
    logic [7:0]           tx_sh;
    logic [HI_BITS-1:0]   addr_hi;
    logic [AW-1:0]        addr_cnt;
    logic [AW-1:0]        addr_in_page;
    logic                 rw;
    logic                 mack;
    logic                 wr_pending;
    logic                 byte_done;
    logic                 quiet;
    logic                 buf_we;
    logic                 buf_clr;
    logic                 commit_go;
    logic                 commit_active;
    logic [7:0]           rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (bus_evt)
    );

    eeprom_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (commit_go),
        .busy  (busy)
    );

    eeprom_page_store #(.PAGE_BITS(PAGE_BITS), .OFFS_BITS(OFFS_BITS)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .buf_clr       (buf_clr),
        .buf_we        (buf_we),
        .buf_off       (addr_cnt[OFFS_BITS-1:0]),
        .buf_wdata     (rx_sh),
        .commit_go     (commit_go),
        .commit_page   (addr_cnt[AW-1:OFFS_BITS]),
        .rd_addr       (addr_cnt),
        .rd_data       (rd_data),
        .commit_active (commit_active)
    );

    assign byte_done    = bus_evt.scl_fall && (bitcnt == 4'd8);
    assign quiet        = !bus_evt.start && !bus_evt.stop;
    assign buf_we       = quiet && (state == S_WDAT) && byte_done;
    assign buf_clr      = quiet && (state == S_ALO) && byte_done;
    assign commit_go    = bus_evt.stop && wr_pending;
    assign addr_in_page = {addr_cnt[AW-1:OFFS_BITS],
                           addr_cnt[OFFS_BITS-1:0] + OFFS_BITS'(1)};

    // next-state logic
    always_comb begin
        state_nx = state;
        if (bus_evt.stop) begin
            state_nx = S_IDLE;
        end else if (bus_evt.start) begin
            state_nx = busy ? S_IDLE : S_DEV;
        end else begin
            unique case (state)
                S_IDLE:     state_nx = S_IDLE;
                S_DEV:      if (byte_done)
                                state_nx = (rx_sh[7:1] == DEV_ADDR && !busy) ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK:  if (bus_evt.scl_fall) state_nx = rw ? S_RDAT : S_AHI;
                S_AHI:      if (byte_done) state_nx = S_AHI_ACK;
                S_AHI_ACK:  if (bus_evt.scl_fall) state_nx = S_ALO;
                S_ALO:      if (byte_done) state_nx = S_ALO_ACK;
                S_ALO_ACK:  if (bus_evt.scl_fall) state_nx = S_WDAT;
                S_WDAT:     if (byte_done) state_nx = S_WDAT_ACK;
                S_WDAT_ACK: if (bus_evt.scl_fall) state_nx = S_WDAT;
                S_RDAT:     if (bus_evt.scl_fall && bitcnt == 4'd7) state_nx = S_RACK;
                S_RACK:     if (bus_evt.scl_fall) state_nx = mack ? S_RDAT : S_IDLE;
                default:    state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            rx_sh      <= '0;
            tx_sh      <= 8'hFF;
            addr_hi    <= '0;
            addr_cnt   <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            wr_pending <= 1'b0;
        end else if (!quiet) begin
            bitcnt     <= '0;
            wr_pending <= 1'b0;
        end else begin
            unique case (state)
                S_DEV, S_AHI, S_ALO, S_WDAT: begin
                    if (bus_evt.scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], bus_evt.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == S_DEV) rw <= rx_sh[0];
                        if (state == S_AHI) addr_hi <= rx_sh[HI_BITS-1:0];
                        if (state == S_ALO) addr_cnt <= {addr_hi, rx_sh};
                        if (state == S_WDAT) begin
                            addr_cnt   <= addr_in_page;
                            wr_pending <= 1'b1;
                        end
                    end
                end
                S_DEV_ACK: begin
                    if (bus_evt.scl_fall && rw) begin
                        tx_sh    <= rd_data;
                        addr_cnt <= addr_cnt + AW'(1);
                    end
                end
                S_RDAT: begin
                    if (bus_evt.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            bitcnt <= '0;
                        end else begin
                            tx_sh  <= {tx_sh[6:0], 1'b1};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                S_RACK: begin
                    if (bus_evt.scl_rise) begin
                        mack <= ~bus_evt.sda;
                    end else if (bus_evt.scl_fall && mack) begin
                        tx_sh    <= rd_data;
                        addr_cnt <= addr_cnt + AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // output register: open-drain pull enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                S_DEV_ACK, S_AHI_ACK, S_ALO_ACK, S_WDAT_ACK: sda_oe <= 1'b1;
                S_RDAT:  sda_oe <= ~tx_sh[7];
                default: sda_oe <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker #(
    parameter int WR_CYCLES = 600
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic busy,
    input logic stop_evt,
    input logic commit_active
);

    logic [31:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (busy) begin
            busy_len <= busy_len + 32'd1;
        end else begin
            busy_len <= '0;
        end
    end

    // R6: no pull on SDA during the write cycle
    assert_quiet_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R5: write cycle lasts exactly WR_CYCLES clocks
    assert_cycle_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == WR_CYCLES));

    // R5: write cycle begins one clock after a STOP
    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R5: array commit stays inside the busy window
    assert_commit_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_active |-> busy);

    // R10: SDA pull changes only with SCL low
    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

endmodule

bind eeprom_i2c_target eeprom_i2c_checker #(.WR_CYCLES(WR_CYCLES)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .sda_oe        (sda_oe),
    .busy          (busy),
    .stop_evt      (bus_evt.stop),
    .commit_active (commit_active)
);

// File: tb/test_eeprom_i2c_target.sv
`timescale 1ns/1ps
module test_eeprom_i2c_target;

    localparam logic [6:0] DEV   = 7'h50;
    localparam int         PB    = 4;
    localparam int         OB    = 6;
    localparam int         WRC   = 600;
    localparam int         DEPTH = 1 << (PB + OB);
    localparam int         PSZ   = 1 << OB;
    localparam int         Q     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda;
    logic sda_oe;
    logic busy;

    int n_checks = 0;
    int n_err = 0;
    int bcnt = 0;
    int shadow [DEPTH];
    bit done = 1'b0;
    bit oe_in_busy = 1'b0;
    bit oe_scl_high = 1'b0;
    logic oe_prev = 1'b0;

    always #2.5 clk = ~clk;

    assign sda = ~(m_low | sda_oe);

    eeprom_i2c_target #(
        .DEV_ADDR(DEV), .PAGE_BITS(PB), .OFFS_BITS(OB), .WR_CYCLES(WRC), .SYNC_STAGES(2)
    ) i_eeprom_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe), .busy(busy)
    );

    always @(negedge clk) begin
        if (busy) bcnt++;
        if (busy && sda_oe) oe_in_busy = 1'b1;
        if (rst_n && (sda_oe !== oe_prev) && scl) oe_scl_high = 1'b1;
        oe_prev = sda_oe;
    end

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    function automatic int dval(input int seed, input int k);
        return (seed * 53 + k * 29 + 7) & 255;
    endfunction

    task automatic i2c_start();
        if (scl == 1'b0) begin
            m_low = 1'b0; qw(); scl = 1'b1; qw();
        end
        m_low = 1'b1; qw(); scl = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        end
        m_low = 1'b0; qw(); scl = 1'b1; qw();
        acked = (sda == 1'b0);
        qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl = 1'b1; qw(); b[i] = sda; qw(); scl = 1'b0; qw();
        end
        m_low = give_ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        m_low = 1'b0;
    endtask

    task automatic send_addr(input int wa);
        bit a;
        send_byte({DEV, 1'b0}, a); chk("R2 device address ack", a, 1);
        send_byte(8'((wa >> 8) & 255), a); chk("R3 high address ack", a, 1);
        send_byte(8'(wa & 255), a); chk("R3 low address ack", a, 1);
    endtask

    task automatic do_write(input int wa, input int n, input int seed);
        bit a;
        int eff;
        eff = wa & (DEPTH - 1);
        i2c_start();
        send_addr(wa);
        for (int k = 0; k < n; k++) begin
            send_byte(8'(dval(seed, k)), a);
            chk("R4 data byte ack", a, 1);
            shadow[(eff & ~(PSZ - 1)) | ((eff + k) & (PSZ - 1))] = dval(seed, k);
        end
        bcnt = 0;
        i2c_stop();
    endtask

    task automatic finish_write();
        chk("R5 busy after STOP", busy, 1);
        while (busy) @(negedge clk);
        chk("R5 write cycle length", bcnt, WRC);
    endtask

    task automatic read_body(input int first, input int n);
        bit a;
        logic [7:0] b;
        send_byte({DEV, 1'b1}, a); chk("R8 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            if (shadow[(first + i) % DEPTH] >= 0)
                chk("R8 read data", b, shadow[(first + i) % DEPTH]);
        end
        chk("R8 SDA released after NACK", sda_oe, 0);
        i2c_stop();
    endtask

    task automatic do_read(input int wa, input int n);
        i2c_start();
        send_addr(wa);
        i2c_start();
        read_body(wa & (DEPTH - 1), n);
    endtask

    task automatic cur_read(input int first, input int n);
        i2c_start();
        read_body(first, n);
    endtask

    initial begin
        bit a;
        for (int i = 0; i < DEPTH; i++) shadow[i] = -1;
        repeat (5) @(negedge clk);
        chk("R1 sda_oe in reset", sda_oe, 0);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 busy after reset", busy, 0);

        // full page 0, then an address attempt during the write cycle
        do_write(0, PSZ, 1);
        chk("R5 busy after STOP", busy, 1);
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        chk("R6 own address ignored while busy", a, 0);
        i2c_stop();
        while (busy) @(negedge clk);
        chk("R5 write cycle length", bcnt, WRC);
        chk("R6 no SDA pull while busy", oe_in_busy, 0);

        // full top page
        do_write(DEPTH - PSZ, PSZ, 2);
        finish_write();
        do_read(0, PSZ);
        do_read(DEPTH - PSZ, PSZ);

        // short write inside a filled page
        do_write(10, 3, 3);
        finish_write();
        do_read(8, 7);

        // in-page wrap, neighbour page preset
        do_write(4 * PSZ, 2, 4);
        finish_write();
        do_write(3 * PSZ + 60, 70, 5);
        finish_write();
        do_read(3 * PSZ, PSZ + 2);

        // R3 ignored upper word-address bits
        do_write(16'hFC00 | 672, 4, 6);
        finish_write();
        do_read(672, 4);
        do_read(16'h4000 | 672, 2);

        // R8 read wraps past top address
        do_read(DEPTH - 2, 4);

        // R7 address-only transfer, R9 counter persists
        i2c_start();
        send_addr(DEPTH - PSZ + 5);
        i2c_stop();
        repeat (50) @(negedge clk);
        chk("R7 no write cycle without data", busy, 0);
        cur_read(DEPTH - PSZ + 5, 3);
        cur_read(DEPTH - PSZ + 8, 2);

        // R2 wrong device address, following byte ignored
        i2c_start();
        send_byte({DEV ^ 7'h01, 1'b0}, a);
        chk("R2 foreign address not acked", a, 0);
        send_byte(8'h55, a);
        chk("R2 bytes after mismatch ignored", a, 0);
        i2c_stop();
        repeat (20) @(negedge clk);
        chk("R2 no write cycle after mismatch", busy, 0);

        chk("R10 SDA pull moved only with SCL low", oe_scl_high, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule